// File: doc/BRIEF.md
# Static Memory Strobe Sequencer

This block produces the control strobes for one chip select of an asynchronous static memory bus. A host raises a request with a direction bit and four configuration words. The block takes the request only when it is idle. It then turns the compact timing fields for that direction into cycle counts and runs a single access. During the access it drives an active-low chip select and one active-low data strobe: the read strobe for a read, the write strobe for a write.

Each of the two strobes has its own setup and pulse length, and both sit inside one shared access length. The access runs for the programmed cycle length, or longer if a strobe window would end after it. An external wait input can freeze the access, act as a ready signal that stretches the end of the data strobe pulse, or be ignored. A read returns the bus value sampled at the rising edge of the chip select or of the read strobe, masked to the configured bus width. After a read the block inserts a data-float gap of 1 to 16 cycles before it accepts the next request. A mode bit lets a new request skip that gap.

Top module: `smc_strobe_gen`

## Requirements
- R1: A setup field is the low 6 bits of a byte and means 128 × bit5 + bits[4:0] cycles. The bytes of the setup word are: byte 0 write strobe, byte 1 write chip select, byte 2 read strobe, byte 3 read chip select.
- R2: A pulse field is the low 7 bits of the same byte of the pulse word and means 256 × bit6 + bits[5:0] cycles.
- R3: A cycle field is 9 bits and means 256 × bits[8:7] + bits[6:0] cycles. The write cycle sits in cycle_word[8:0] and the read cycle in cycle_word[24:16].
- R4: Count cycle 0 as the first clock cycle after the accepting edge. A strobe is then low in cycles setup through setup+pulse−1, and a pulse of 0 leaves it high. The chip select uses the chip-select fields of the access direction. rd_n moves only on reads and wr_n only on writes.
- R5: An access lasts max(cycle, chip-select setup+pulse, data-strobe setup+pulse) cycles, with a minimum of 1. done is high for exactly the last cycle of the access.
- R6: req_ready is high when idle and low during an access. A request is accepted on a clock edge where req_valid and req_ready are both high.
- R7: With mode bit 0 clear, a read captures rd_bus at the clock edge that ends the last low cycle of cs_n. With mode bit 0 set, it uses rd_n instead. If the chosen strobe has no pulse, the capture happens at the edge that ends the access.
- R8: With mode bit 1 clear, wr_drive is high from cycle 0 up to the rising edge of cs_n on a write. With mode bit 1 set, it is high up to the rising edge of wr_n instead. If the chosen strobe has no pulse, it stays high for the whole access.
- R9: Mode bits [5:4] = 0 ignore ext_wait. A value of 2 holds the cycle counter in every cycle where ext_wait is high.
- R10: Mode bits [5:4] = 3 hold the counter on the last low cycle of the data strobe while ext_wait is high. ext_wait has no effect anywhere else.
- R11: After a read, req_ready stays low for mode[19:16]+1 cycles. If mode bit 20 is set, it is high again at once.
- R12: Mode bits [13:12] mask the captured read data: 0 keeps 8 bits, 1 keeps 16 bits, 2 keeps 32 bits. The upper bits read as zero.
- R13: During reset and while idle, cs_n, rd_n and wr_n are high, wr_drive and done are low, and rd_data is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Request can be taken |
| setup_word | input | 32 | Four packed setup fields |
| pulse_word | input | 32 | Four packed pulse fields |
| cycle_word | input | 32 | Write and read cycle fields |
| mode_word | input | 32 | Capture, drive, wait, width and float controls |
| ext_wait | input | 1 | External wait / not-ready, active high |
| rd_bus | input | DATA_W | Memory read data |
| rd_data | output | DATA_W | Captured, width-masked read data |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| wr_drive | output | 1 | Write data should be driven |
| done | output | 1 | Last cycle of the access |

## Verification
The strobes, wr_drive, done and req_ready all decode directly from the registered cycle counter. The bench therefore samples them half a clock after each edge and compares them with the cycle index its own model holds. It sets ext_wait and rd_bus at the falling edge before that comparison, because done depends on whether the counter advances. rd_data changes at the edge that ends the capture cycle, so it is checked one falling edge after done. The float gap is measured by counting falling edges with req_ready low, starting at the first falling edge after the read completes.

// File: rtl/smc_strobe_pkg.sv
package smc_strobe_pkg;
  localparam int CNT_W   = 10;
  localparam int FLT_W   = 4;
  localparam int NUM_FLD = 4;
  localparam int FLD_WR_STB = 0;
  localparam int FLD_WR_CS  = 1;
  localparam int FLD_RD_STB = 2;
  localparam int FLD_RD_CS  = 3;
  localparam int MB_RD_CAP  = 0;
  localparam int MB_WR_END  = 1;
  localparam int MB_FSKIP   = 20;

  typedef enum logic [1:0] {
    WAIT_OFF    = 2'd0,
    WAIT_RSVD   = 2'd1,
    WAIT_FREEZE = 2'd2,
    WAIT_READY  = 2'd3
  } wait_mode_e;

  typedef struct packed {
    logic             is_write;
    logic [CNT_W-1:0] cs_set;
    logic [CNT_W-1:0] cs_end;
    logic [CNT_W-1:0] ds_set;
    logic [CNT_W-1:0] ds_end;
    logic             ds_live;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] sel_lim;
    wait_mode_e       wait_mode;
    logic [1:0]       width;
    logic [FLT_W-1:0] float_m1;
    logic             float_skip;
  } acc_cfg_t;

  // multiplier bit lands on bit 7: 128*b5 + b[4:0]
  function automatic logic [CNT_W-1:0] dec_setup(input logic [5:0] f);
    return CNT_W'({f[5], 2'b00, f[4:0]});
  endfunction

  // multiplier bit lands on bit 8: 256*b6 + b[5:0]
  function automatic logic [CNT_W-1:0] dec_pulse(input logic [6:0] f);
    return CNT_W'({f[6], 2'b00, f[5:0]});
  endfunction

  // two high bits land on bits 9:8: 256*b[8:7] + b[6:0]
  function automatic logic [CNT_W-1:0] dec_cycle(input logic [8:0] f);
    return CNT_W'({f[8:7], 1'b0, f[6:0]});
  endfunction
endpackage

// File: rtl/smc_rst_sync.sv
module smc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/smc_timing_decode.sv
module smc_timing_decode
  import smc_strobe_pkg::*;
(
  input  logic [31:0] setup_word,
  input  logic [31:0] pulse_word,
  input  logic [31:0] cycle_word,
  input  logic [31:0] mode_word,
  input  logic        is_write,
  output acc_cfg_t    cfg
);
  logic [CNT_W-1:0] set_len [NUM_FLD];
  logic [CNT_W-1:0] pul_len [NUM_FLD];
  logic [CNT_W-1:0] cyc_wr, cyc_rd;

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
    assign set_len[g] = dec_setup(setup_word[8*g +: 6]);
    assign pul_len[g] = dec_pulse(pulse_word[8*g +: 7]);
  end

  assign cyc_wr = dec_cycle(cycle_word[8:0]);
  assign cyc_rd = dec_cycle(cycle_word[24:16]);

  logic unused_bits;
  assign unused_bits = ^{setup_word[31:30], setup_word[23:22], setup_word[15:14],
                         setup_word[7:6], pulse_word[31], pulse_word[23],
                         pulse_word[15], pulse_word[7], cycle_word[31:25],
                         cycle_word[15:9], mode_word[31:21], mode_word[15:14],
                         mode_word[11:6], mode_word[3:2]};

  always_comb begin
    int               ci, di;
    logic             cs_live, sel;
    logic [CNT_W-1:0] tot;
    ci  = is_write ? FLD_WR_CS  : FLD_RD_CS;
    di  = is_write ? FLD_WR_STB : FLD_RD_STB;
    cfg = '0;
    cfg.is_write = is_write;
    cfg.cs_set   = set_len[ci];
    cfg.cs_end   = set_len[ci] + pul_len[ci];
    cfg.ds_set   = set_len[di];
    cfg.ds_end   = set_len[di] + pul_len[di];
    cfg.ds_live  = (pul_len[di] != '0);
    cs_live      = (pul_len[ci] != '0);
    tot = is_write ? cyc_wr : cyc_rd;
    if (cfg.cs_end > tot) tot = cfg.cs_end;
    if (cfg.ds_end > tot) tot = cfg.ds_end;
    if (tot == '0)        tot = CNT_W'(1);
    cfg.total = tot;
    sel = is_write ? mode_word[MB_WR_END] : mode_word[MB_RD_CAP];
    if (sel) cfg.sel_lim = cfg.ds_live ? cfg.ds_end : tot;
    else     cfg.sel_lim = cs_live     ? cfg.cs_end : tot;
    cfg.wait_mode  = wait_mode_e'(mode_word[5:4]);
    cfg.width      = mode_word[13:12];
    cfg.float_m1   = mode_word[19:16];
    cfg.float_skip = mode_word[MB_FSKIP];
  end
endmodule

// File: rtl/smc_strobe_win.sv
module smc_strobe_win
  import smc_strobe_pkg::*;
(
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] stop,
  output logic             strobe_n
);
  assign strobe_n = !(active && (cnt >= start) && (cnt < stop));
endmodule

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen
  import smc_strobe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ready,
  input  logic [31:0]       setup_word,
  input  logic [31:0]       pulse_word,
  input  logic [31:0]       cycle_word,
  input  logic [31:0]       mode_word,
  input  logic              ext_wait,
  input  logic [DATA_W-1:0] rd_bus,
  output logic [DATA_W-1:0] rd_data,
  output logic              cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              wr_drive,
  output logic              done
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_FLT} st_e;

  logic             rst_ni;
  st_e              st_q, st_d;
  acc_cfg_t         cfg_q, cfg_d, cfg_new;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FLT_W-1:0] flt_q, flt_d;
  logic [DATA_W-1:0] rdat_q, rdat_d, rmask;
  logic             in_acc, adv, last, accept, cap_en, hold_frz, hold_rdy;

  smc_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  smc_timing_decode u_dec (
    .setup_word(setup_word), .pulse_word(pulse_word), .cycle_word(cycle_word),
    .mode_word(mode_word), .is_write(req_write), .cfg(cfg_new)
  );

  assign in_acc   = (st_q == ST_ACC);
  assign hold_frz = (cfg_q.wait_mode == WAIT_FREEZE) && ext_wait;
  assign hold_rdy = (cfg_q.wait_mode == WAIT_READY) && ext_wait && cfg_q.ds_live &&
                    (cnt_q == cfg_q.ds_end - CNT_W'(1));
  assign adv      = in_acc && !hold_frz && !hold_rdy;
  assign last     = (cnt_q == cfg_q.total - CNT_W'(1));
  assign done     = adv && last;
  assign req_ready = (st_q == ST_IDLE) || ((st_q == ST_FLT) && cfg_q.float_skip);
  assign accept   = req_valid && req_ready;
  assign cap_en   = adv && !cfg_q.is_write && (cnt_q == cfg_q.sel_lim - CNT_W'(1));
  assign wr_drive = in_acc && cfg_q.is_write && (cnt_q < cfg_q.sel_lim);

  smc_strobe_win u_cs (.active(in_acc), .cnt(cnt_q), .start(cfg_q.cs_set),
                       .stop(cfg_q.cs_end), .strobe_n(cs_n));
  smc_strobe_win u_rd (.active(in_acc && !cfg_q.is_write), .cnt(cnt_q),
                       .start(cfg_q.ds_set), .stop(cfg_q.ds_end), .strobe_n(rd_n));
  smc_strobe_win u_wr (.active(in_acc && cfg_q.is_write), .cnt(cnt_q),
                       .start(cfg_q.ds_set), .stop(cfg_q.ds_end), .strobe_n(wr_n));

  always_comb begin
    int wbits;
    case (cfg_q.width)
      2'd0:    wbits = 8;
      2'd1:    wbits = 16;
      default: wbits = 32;
    endcase
    for (int b = 0; b < DATA_W; b++) rmask[b] = (b < wbits);
  end

  always_comb begin
    st_d   = st_q;
    cfg_d  = cfg_q;
    cnt_d  = cnt_q;
    flt_d  = flt_q;
    rdat_d = cap_en ? (rd_bus & rmask) : rdat_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d = ST_ACC; cfg_d = cfg_new; cnt_d = '0;
      end
      ST_ACC: if (adv) begin
        if (last) begin
          st_d  = cfg_q.is_write ? ST_IDLE : ST_FLT;
          flt_d = cfg_q.float_m1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_FLT: begin
        if (accept) begin
          st_d = ST_ACC; cfg_d = cfg_new; cnt_d = '0;
        end else if (flt_q == '0) begin
          st_d = ST_IDLE;
        end else begin
          flt_d = flt_q - FLT_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      cnt_q  <= '0;
      flt_q  <= '0;
      rdat_q <= '0;
    end else begin
      st_q   <= st_d;
      cfg_q  <= cfg_d;
      cnt_q  <= cnt_d;
      flt_q  <= flt_d;
      rdat_q <= rdat_d;
    end
  end

  assign rd_data = rdat_q;

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (cs_n && rd_n && wr_n && !wr_drive && !done));
  assert_one_data_strobe_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    !(!rd_n && !wr_n));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  assert_len_covers_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    in_acc |-> (cfg_q.total >= cfg_q.cs_end && cfg_q.total >= cfg_q.ds_end));
  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    in_acc |-> !req_ready);
  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_acc && cfg_q.wait_mode == WAIT_FREEZE && ext_wait) |=> $stable(cnt_q));
  assert_ready_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_acc && cfg_q.wait_mode == WAIT_READY && ext_wait && cfg_q.ds_live &&
     cnt_q == cfg_q.ds_end - CNT_W'(1)) |=> ($stable(cnt_q) && (st_q == ST_ACC)));
  assert_float_gap_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && !cfg_q.is_write && !cfg_q.float_skip) |=> !req_ready);
endmodule

// File: tb/smc_strobe_gen_bench.sv
module smc_strobe_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n, req_valid, req_write, req_ready, ext_wait;
  logic [31:0] setup_word, pulse_word, cycle_word, mode_word, rd_bus, rd_data;
  logic        cs_n, rd_n, wr_n, wr_drive, done;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  smc_strobe_gen #(.DATA_W(32)) u_smc_strobe_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .setup_word(setup_word), .pulse_word(pulse_word),
    .cycle_word(cycle_word), .mode_word(mode_word), .ext_wait(ext_wait),
    .rd_bus(rd_bus), .rd_data(rd_data), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_drive(wr_drive), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int f_setup(input logic [5:0] f);
    return (f[5] ? 128 : 0) + int'(f[4:0]);
  endfunction
  function automatic int f_pulse(input logic [6:0] f);
    return (f[6] ? 256 : 0) + int'(f[5:0]);
  endfunction
  function automatic int f_cycle(input logic [8:0] f);
    return int'(f[8:7]) * 256 + int'(f[6:0]);
  endfunction
  function automatic logic [31:0] f_mask(input logic [1:0] w);
    return (w == 2'd0) ? 32'h0000_00ff : (w == 2'd1) ? 32'h0000_ffff : 32'hffff_ffff;
  endfunction

  task automatic run_access(input logic wr, input logic [31:0] sw, input logic [31:0] pw,
                            input logic [31:0] cw, input logic [31:0] mw, input int wpct,
                            input string t_time, input string t_data);
    int si, ci, ds_s, ds_p, ds_e, cs_s, cs_p, cs_e, tot, lim, mk, wm, expf, n;
    logic selb, hold, adv;
    logic [31:0] exp_data;
    si = wr ? 0 : 16;
    ci = wr ? 8 : 24;
    ds_s = f_setup(sw[si +: 6]); ds_p = f_pulse(pw[si +: 7]); ds_e = ds_s + ds_p;
    cs_s = f_setup(sw[ci +: 6]); cs_p = f_pulse(pw[ci +: 7]); cs_e = cs_s + cs_p;
    tot = wr ? f_cycle(cw[8:0]) : f_cycle(cw[24:16]);
    if (cs_e > tot) tot = cs_e;
    if (ds_e > tot) tot = ds_e;
    if (tot == 0) tot = 1;
    selb = wr ? mw[1] : mw[0];
    lim = selb ? ((ds_p > 0) ? ds_e : tot) : ((cs_p > 0) ? cs_e : tot);
    wm = int'(mw[5:4]);
    exp_data = rd_data;
    setup_word = sw; pulse_word = pw; cycle_word = cw; mode_word = mw;
    req_write = wr; req_valid = 1'b1;
    #1;
    chk("R6 ready before request", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    mk = 0;
    forever begin
      ext_wait = ($urandom_range(99) < wpct);
      rd_bus = $urandom;
      #1;
      chk({t_time, " cs_n"}, {31'd0, cs_n}, {31'd0, !(mk >= cs_s && mk < cs_e)});
      chk({t_time, " rd_n"}, {31'd0, rd_n}, {31'd0, wr || !(mk >= ds_s && mk < ds_e)});
      chk({t_time, " wr_n"}, {31'd0, wr_n}, {31'd0, !wr || !(mk >= ds_s && mk < ds_e)});
      chk("R8 wr_drive", {31'd0, wr_drive}, {31'd0, wr && (mk < lim)});
      chk("R6 ready busy", {31'd0, req_ready}, 32'd0);
      hold = (wm == 2 && ext_wait) || (wm == 3 && ext_wait && ds_p > 0 && mk == ds_e - 1);
      adv = !hold;
      chk({t_time, " R5 done"}, {31'd0, done}, {31'd0, adv && (mk == tot - 1)});
      if (!wr && adv && mk == lim - 1) exp_data = rd_bus & f_mask(mw[13:12]);
      if (adv && mk == tot - 1) break;
      if (adv) mk++;
      @(negedge clk);
    end
    @(negedge clk);
    ext_wait = 1'b0;
    #1;
    chk({t_data, " rd_data"}, rd_data, exp_data);
    expf = wr ? 0 : (mw[MB_SKIP] ? 0 : int'(mw[19:16]) + 1);
    n = 0;
    while (!req_ready && n < 40) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk("R11 float gap", n, expf);
  endtask

  localparam int MB_SKIP = 20;

  function automatic logic [7:0] rnd_set();
    return {2'b00, ($urandom_range(9) == 0), 5'($urandom)};
  endfunction
  function automatic logic [7:0] rnd_pul();
    return {1'b0, ($urandom_range(9) == 0), 6'($urandom)};
  endfunction
  function automatic logic [8:0] rnd_cyc();
    return {(($urandom_range(9) == 0) ? 2'($urandom) : 2'b00), 7'($urandom)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; ext_wait = 1'b0;
    setup_word = '0; pulse_word = '0; cycle_word = '0; mode_word = '0; rd_bus = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R13 reset strobes", {29'd0, cs_n, rd_n, wr_n}, 32'd7);
    chk("R13 reset drive/done", {30'd0, wr_drive, done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R13 rd_data after reset", rd_data, 32'd0);
    chk("R13 idle strobes", {29'd0, cs_n, rd_n, wr_n}, 32'd7);
    chk("R6 idle ready", {31'd0, req_ready}, 32'd1);
    @(negedge clk);

    // write: strobe setup 2, cs setup 0; pulses 3 / 6; cycle 8; end on wr_n
    run_access(1'b1, 32'h0000_0002, 32'h0000_0603, 32'h0000_0008, 32'h0000_0002, 0,
               "R4", "R8");
    // write ending on cs_n, ext_wait toggling but ignored (mode 0)
    run_access(1'b1, 32'h0000_0104, 32'h0000_0402, 32'h0000_0003, 32'h0000_0000, 50,
               "R9 ignore", "R8");
    // read with high setup/pulse bits: 129 + 257 beyond read cycle 257 (extension)
    run_access(1'b0, 32'h0021_0000, 32'h0541_0000, 32'h0081_0000, 32'h0001_2001, 0,
               "R2", "R7");
    // read with cycle high bits 3 -> 770, capture on cs_n, 16-bit width
    run_access(1'b0, 32'h0320_0000, 32'h0407_0000, 32'h0182_0000, 32'h0000_1000, 0,
               "R3", "R12");
    // setup high bit on chip select: 128 + 3
    run_access(1'b0, 32'h2301_0000, 32'h0102_0000, 32'h0004_0000, 32'h0003_0000, 0,
               "R1", "R12");
    // freeze mode, heavy waits
    run_access(1'b0, 32'h0002_0000, 32'h0504_0000, 32'h000c_0000, 32'h0002_0021, 50,
               "R9", "R7");
    // ready mode on write and read
    run_access(1'b1, 32'h0000_0001, 32'h0000_0203, 32'h0000_0004, 32'h0000_0032, 60,
               "R10", "R8");
    run_access(1'b0, 32'h0001_0000, 32'h0304_0000, 32'h0003_0000, 32'h0000_2031, 60,
               "R10", "R7");
    // float 16, 8-bit width, then skip-float read followed at once by a read
    run_access(1'b0, 32'h0000_0000, 32'h0101_0000, 32'h0002_0000, 32'h000f_0000, 0,
               "R4", "R12");
    run_access(1'b0, 32'h0000_0000, 32'h0202_0000, 32'h0003_0000, 32'h0015_2001, 0,
               "R4", "R11");
    run_access(1'b0, 32'h0001_0000, 32'h0202_0000, 32'h0001_0000, 32'h0000_2000, 0,
               "R11", "R7");
    // zero pulse on data strobe: never asserted, capture at end; all-zero timings
    run_access(1'b0, 32'h0003_0000, 32'h0300_0000, 32'h0005_0000, 32'h0000_2001, 0,
               "R4", "R7");
    run_access(1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0002, 0,
               "R5", "R8");

    for (int i = 0; i < 40; i++) begin
      logic        w;
      logic [31:0] sw, pw, cw, mw;
      logic [1:0]  wmode;
      w  = 1'($urandom);
      sw = {rnd_set(), rnd_set(), rnd_set(), rnd_set()};
      pw = {rnd_pul(), rnd_pul(), rnd_pul(), rnd_pul()};
      cw = {7'd0, rnd_cyc(), 7'd0, rnd_cyc()};
      case ($urandom_range(2))
        0:       wmode = 2'd0;
        1:       wmode = 2'd2;
        default: wmode = 2'd3;
      endcase
      mw = {11'd0, 1'($urandom), 4'($urandom), 2'b00, 2'($urandom_range(2)),
            6'd0, wmode, 2'b00, 2'($urandom)};
      run_access(w, sw, pw, cw, mw, 30, "R4 rnd", "R12 rnd");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule